// File: doc/BRIEF.md
# Host Bus Page Aperture Mapper

This block sits beside an 8-bit host processor and watches its 16-bit address bus, its data bus and its read/write strobe. The host programs a small set of window descriptors. Each descriptor holds a first host page, a last host page, a page offset into a large external byte store, and an enable flag. A host page is 256 bytes. When a host bus cycle falls inside an enabled window, the block claims the bus and translates the host address into an external store address. On a read it fetches the byte through a request port and drives it onto the host data bus. On a write it forwards the byte to the store.

The descriptors are reached through one reserved host page, the configuration page. That page is never remapped. A host bus cycle is framed by `hb_cyc`. The address and direction are taken on the first clock of the cycle, and write data is taken on the last clock before `hb_cyc` falls. Consecutive host cycles are separated by at least one idle clock.

The store port is a valid/ready request channel followed by a one-clock completion pulse. A request that is not accepted is held with all of its fields unchanged until `mem_req_ready` is seen high. The store may stall for as long as it needs. However, a read completion must come before the host's data deadline, and a write must be accepted before the next host cycle begins.

Top module: `host_aperture_ctrl`

## Requirements
- R1: After reset every descriptor is disabled and all of its fields are zero. `hb_claim`, `hb_oe`, `hb_dir` and `mem_req_valid` are low, and a read of any configuration register returns 0.
- R2: A descriptor matches when it is enabled and first_page <= addr[15:8] <= last_page, inclusive at both ends. A descriptor whose last page is below its first page never matches. Clearing the enable bit removes the match.
- R3: When several enabled descriptors match, the one with the lowest index serves the access.
- R4: The store address is ((offset + addr[15:8] - first_page) * 256) + addr[7:0]. The offset is a 21-bit page number, so the store address is 29 bits wide.
- R5: A matched read issues exactly one read request (`mem_req_we`=0). `hb_oe` and `hb_dir` stay low until the completion pulse has been seen. They are then high, with `hb_rdata` equal to the returned byte, until `hb_cyc` falls, and low from that clock on.
- R6: A matched write issues exactly one write request (`mem_req_we`=1) after `hb_cyc` falls. The request carries the translated address and the byte the host presented on the last clock of the cycle. `hb_oe` stays low during the write.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid on the next clock and its address, direction and byte are unchanged.
- R8: The configuration page, parameter CFG_PAGE (default 0xBF), holds descriptor n at byte offsets 8n to 8n+4. The fields are: +0 first page, +1 last page, +2 offset[7:0], +3 offset[15:8], and +4 with bit 7 = enable and bits 4:0 = offset[20:16]. Host writes update a field, and host reads return it on `hb_rdata` with `hb_oe` high. The page never matches a descriptor, even one whose range covers it, and it never produces a store request.
- R9: A host cycle that matches no descriptor and is not in the configuration page leaves `hb_claim` and `hb_oe` low and produces no store request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the host bus |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_cyc | input | 1 | High for the duration of one host bus cycle |
| hb_rnw | input | 1 | 1 = host read, 0 = host write |
| hb_addr | input | 16 | Host address |
| hb_wdata | input | 8 | Byte driven by the host on a write |
| hb_rdata | output | 8 | Byte the block drives onto the host data bus |
| hb_oe | output | 1 | Enable for the block's host data-bus drivers |
| hb_dir | output | 1 | Transceiver direction, 1 = toward the host |
| hb_claim | output | 1 | The block owns the current host cycle |
| mem_req_valid | output | 1 | Store request valid |
| mem_req_ready | input | 1 | Store accepts the request |
| mem_req_we | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 29 | Translated byte address in the store |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_done | input | 1 | One-clock pulse marking completion of a read |
| mem_rsp_data | input | 8 | Read byte, valid with `mem_rsp_done` |

## Verification
The bench uses the default build: four descriptors with a configuration page of 0xBF. Four descriptors are enough to set up an inverted range, two overlapping windows for the priority rule and one window that spans all 256 pages. The spanning window tests that the configuration page is excluded from remapping. The store model stalls on request acceptance, which exercises the hold rule on the request channel. Its read latency of several clocks makes the interval before the data-drive enable opens observable.

// File: rtl/hbap_pkg.sv
package hbap_pkg;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 21;
  localparam int STORE_AW = OFF_W + PAGE_W;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] first;
    logic [PAGE_W-1:0] last;
    logic [OFF_W-1:0]  base;
  } win_desc_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SKIP, ST_CFG_RD, ST_CFG_WR,
    ST_RD_REQ, ST_RD_WAIT, ST_RD_DRV, ST_WR_HOLD, ST_WR_REQ
  } bus_state_t;
endpackage

// File: rtl/hbap_desc_regs.sv
module hbap_desc_regs
  import hbap_pkg::*;
#(
  parameter int NDESC = 4,
  localparam int IDXW = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            reg_off,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output win_desc_t [NDESC-1:0] descs
);
  logic [IDXW-1:0] sel;
  logic [2:0]      field;
  logic            in_map;

  assign sel    = reg_off[3 +: IDXW];
  assign field  = reg_off[2:0];
  assign in_map = (32'(reg_off[7:3]) < NDESC);

  for (genvar g = 0; g < NDESC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        descs[g] <= '0;
      end else if (wr_en && in_map && (32'(sel) == g)) begin
        case (field)
          3'd0: descs[g].first <= wr_data;
          3'd1: descs[g].last <= wr_data;
          3'd2: descs[g].base[7:0] <= wr_data;
          3'd3: descs[g].base[15:8] <= wr_data;
          3'd4: begin
            descs[g].en <= wr_data[7];
            descs[g].base[20:16] <= wr_data[4:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_map) begin
      case (field)
        3'd0: rd_data = descs[sel].first;
        3'd1: rd_data = descs[sel].last;
        3'd2: rd_data = descs[sel].base[7:0];
        3'd3: rd_data = descs[sel].base[15:8];
        3'd4: rd_data = {descs[sel].en, 2'b00, descs[sel].base[20:16]};
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/hbap_match.sv
module hbap_match
  import hbap_pkg::*;
#(
  parameter int NDESC = 4,
  parameter logic [7:0] CFG_PAGE = 8'hBF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_W-1:0]     page,
  input  win_desc_t [NDESC-1:0] descs,
  output logic                  hit,
  output logic [OFF_W-1:0]      xpage
);
  logic [NDESC-1:0] in_rng;
  logic [NDESC-1:0] winner;

  for (genvar g = 0; g < NDESC; g++) begin : g_cmp
    assign in_rng[g] = descs[g].en && (page >= descs[g].first) &&
                       (page <= descs[g].last) && (page != CFG_PAGE);
  end

  always_comb begin
    winner = '0;
    xpage  = '0;
    for (int i = NDESC - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        winner = '0;
        winner[i] = 1'b1;
        xpage = descs[i].base + OFF_W'(page - descs[i].first);
      end
    end
  end

  assign hit = |in_rng;

  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));
  a_r8_cfg_page_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (page != CFG_PAGE));
endmodule

// File: rtl/hbap_bus_seq.sv
module hbap_bus_seq
  import hbap_pkg::*;
#(
  parameter logic [7:0] CFG_PAGE = 8'hBF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hb_cyc,
  input  logic                hb_rnw,
  input  logic [15:0]         hb_addr,
  input  logic [7:0]          hb_wdata,
  output logic [7:0]          hb_rdata,
  output logic                hb_oe,
  output logic                hb_dir,
  output logic                hb_claim,
  input  logic                hit,
  input  logic [OFF_W-1:0]    xpage,
  output logic                cfg_we,
  output logic [7:0]          cfg_off,
  output logic [7:0]          cfg_wdata,
  input  logic [7:0]          cfg_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [STORE_AW-1:0] mem_req_addr,
  output logic [7:0]          mem_req_wdata,
  input  logic                mem_rsp_done,
  input  logic [7:0]          mem_rsp_data
);
  bus_state_t state;
  logic [7:0] wd_q, wd_hold, rd_q, off_q;
  logic [STORE_AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wd_q    <= '0;
      wd_hold <= '0;
      rd_q    <= '0;
      off_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (hb_cyc) wd_q <= hb_wdata;
      case (state)
        ST_IDLE: if (hb_cyc) begin
          off_q  <= hb_addr[7:0];
          addr_q <= {xpage, hb_addr[7:0]};
          if (hb_addr[15:8] == CFG_PAGE) state <= hb_rnw ? ST_CFG_RD : ST_CFG_WR;
          else if (hit) state <= hb_rnw ? ST_RD_REQ : ST_WR_HOLD;
          else state <= ST_SKIP;
        end
        ST_SKIP, ST_CFG_RD, ST_CFG_WR, ST_RD_DRV: if (!hb_cyc) state <= ST_IDLE;
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_done) begin
          rd_q  <= mem_rsp_data;
          state <= hb_cyc ? ST_RD_DRV : ST_IDLE;
        end
        ST_WR_HOLD: if (!hb_cyc) begin
          wd_hold <= wd_q;
          state   <= ST_WR_REQ;
        end
        ST_WR_REQ: if (mem_req_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hb_oe    = hb_cyc && ((state == ST_RD_DRV) || (state == ST_CFG_RD));
  assign hb_dir   = hb_oe;
  assign hb_rdata = (state == ST_CFG_RD) ? cfg_rdata : rd_q;
  assign hb_claim = hb_cyc && (state inside {ST_CFG_RD, ST_CFG_WR, ST_RD_REQ,
                                             ST_RD_WAIT, ST_RD_DRV, ST_WR_HOLD});

  assign cfg_we    = (state == ST_CFG_WR) && !hb_cyc;
  assign cfg_off   = off_q;
  assign cfg_wdata = wd_q;

  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_we    = (state == ST_WR_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wd_hold;

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));
  a_r5_drive_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD_DRV) && ($past(state) != ST_RD_DRV)) |-> $past(mem_rsp_done));
  a_r6_write_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && !$past(mem_req_valid)) |-> $past(!hb_cyc));
  a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> !hb_oe);
endmodule

// File: rtl/host_aperture_ctrl.sv
module host_aperture_ctrl
  import hbap_pkg::*;
#(
  parameter int NDESC = 4,
  parameter logic [7:0] CFG_PAGE = 8'hBF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hb_cyc,
  input  logic                hb_rnw,
  input  logic [15:0]         hb_addr,
  input  logic [7:0]          hb_wdata,
  output logic [7:0]          hb_rdata,
  output logic                hb_oe,
  output logic                hb_dir,
  output logic                hb_claim,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [28:0]         mem_req_addr,
  output logic [7:0]          mem_req_wdata,
  input  logic                mem_rsp_done,
  input  logic [7:0]          mem_rsp_data
);
  win_desc_t [NDESC-1:0] descs;
  logic             hit, cfg_we;
  logic [OFF_W-1:0] xpage;
  logic [7:0]       cfg_off, cfg_wdata, cfg_rdata;

  hbap_desc_regs #(.NDESC(NDESC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .reg_off(cfg_off),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .descs(descs)
  );

  hbap_match #(.NDESC(NDESC), .CFG_PAGE(CFG_PAGE)) u_match (
    .clk(clk), .rst_n(rst_n), .page(hb_addr[15:8]), .descs(descs),
    .hit(hit), .xpage(xpage)
  );

  hbap_bus_seq #(.CFG_PAGE(CFG_PAGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .hb_cyc(hb_cyc), .hb_rnw(hb_rnw),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_oe(hb_oe), .hb_dir(hb_dir), .hb_claim(hb_claim),
    .hit(hit), .xpage(xpage), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_done(mem_rsp_done),
    .mem_rsp_data(mem_rsp_data)
  );

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_cyc |-> (!hb_oe && !hb_claim));
endmodule

// File: tb/test_host_aperture_ctrl.sv
module test_host_aperture_ctrl;
  localparam time TCLK = 10ns;
  localparam logic [7:0] CFG = 8'hBF;

  logic clk = 0, rst_n = 0;
  logic hb_cyc = 0, hb_rnw = 1;
  logic [15:0] hb_addr = '0;
  logic [7:0] hb_wdata = '0, hb_rdata;
  logic hb_oe, hb_dir, hb_claim;
  logic mem_req_valid, mem_req_ready, mem_req_we;
  logic [28:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_done = 0;
  logic [7:0] mem_rsp_data = '0;

  int checks = 0, fails = 0;
  int gap = 0, wait_cnt = 0, lat = 0, req_cnt = 0;
  logic [28:0] last_addr = '0, pend = '0;
  logic last_we = 0;
  logic [7:0] last_wd = '0;

  always #(TCLK/2) clk = ~clk;

  host_aperture_ctrl #(.NDESC(4), .CFG_PAGE(CFG)) i_host_aperture_ctrl (
    .clk(clk), .rst_n(rst_n), .hb_cyc(hb_cyc), .hb_rnw(hb_rnw),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_oe(hb_oe), .hb_dir(hb_dir), .hb_claim(hb_claim),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_done(mem_rsp_done),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mdata(input logic [28:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {3'b000, a[28:24]} ^ 8'hA5;
  endfunction

  // store model: stalls acceptance for 'gap' clocks, answers reads after 3 clocks
  assign mem_req_ready = (wait_cnt >= gap);
  always @(posedge clk) begin
    mem_rsp_done <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_done <= 1'b1;
        mem_rsp_data <= mdata(pend);
      end
    end
    if (mem_req_valid) begin
      if (mem_req_ready) begin
        wait_cnt <= 0;
        req_cnt <= req_cnt + 1;
        last_addr <= mem_req_addr;
        last_we <= mem_req_we;
        last_wd <= mem_req_wdata;
        if (!mem_req_we) begin
          lat <= 3;
          pend <= mem_req_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic c_mid, oe_early, oe_end, oe_after;
  logic [7:0] rd_end;

  task automatic bus(input logic [15:0] a, input logic rnw, input logic [7:0] wd);
    @(negedge clk);
    hb_cyc = 1; hb_addr = a; hb_rnw = rnw; hb_wdata = wd;
    @(negedge clk);
    oe_early = hb_oe; c_mid = hb_claim;
    repeat (9) @(negedge clk);
    oe_end = hb_oe; rd_end = hb_rdata;
    hb_cyc = 0;
    @(negedge clk);
    oe_after = hb_oe;
    repeat (8) @(negedge clk);
  endtask

  task automatic cfg_wr(input int d, input int f, input logic [7:0] v);
    bus({CFG, 8'(d * 8 + f)}, 1'b0, v);
  endtask

  task automatic t_reset;
    chk(!hb_claim && !hb_oe && !hb_dir && !mem_req_valid, "R1 idle outputs",
        {hb_claim, hb_oe, hb_dir, mem_req_valid}, 0);
    bus({CFG, 8'h04}, 1'b1, 8'h00);
    chk(rd_end == 8'h00 && oe_end, "R1 enable field zero", rd_end, 0);
    bus({CFG, 8'h00}, 1'b1, 8'h00);
    chk(rd_end == 8'h00, "R1 first-page field zero", rd_end, 0);
    bus(16'h4000, 1'b1, 8'h00);
    chk(!c_mid && !oe_end && req_cnt == 0, "R9 no claim after reset",
        {c_mid, oe_end, 8'(req_cnt)}, 0);
  endtask

  task automatic t_read;
    int n0;
    logic [28:0] ea;
    cfg_wr(0, 0, 8'h40); cfg_wr(0, 1, 8'h4F); cfg_wr(0, 2, 8'h45);
    cfg_wr(0, 3, 8'h23); cfg_wr(0, 4, 8'h81);
    n0 = req_cnt;
    ea = {21'h12345 + 21'd5, 8'h23};
    bus(16'h4523, 1'b1, 8'h00);
    chk(req_cnt == n0 + 1 && !last_we, "R5 one read request", req_cnt - n0, 1);
    chk(last_addr == ea, "R4 translated address", last_addr, ea);
    chk(!oe_early, "R5 oe low before done", oe_early, 0);
    chk(oe_end && hb_dir == 0 && rd_end == mdata(ea), "R5 drive returned byte",
        rd_end, mdata(ea));
    chk(!oe_after, "R5 oe released at cycle end", oe_after, 0);
  endtask

  task automatic t_bounds;
    int n0;
    bus(16'h4000, 1'b1, 8'h00);
    chk(c_mid && last_addr == {21'h12345, 8'h00}, "R2 first page inclusive",
        last_addr, {21'h12345, 8'h00});
    bus(16'h4FFF, 1'b1, 8'h00);
    chk(c_mid && last_addr == {21'h12354, 8'hFF}, "R2 last page inclusive",
        last_addr, {21'h12354, 8'hFF});
    n0 = req_cnt;
    bus(16'h3FFF, 1'b1, 8'h00);
    chk(!c_mid && !oe_end && req_cnt == n0, "R9 below window", c_mid, 0);
    bus(16'h5000, 1'b1, 8'h00);
    chk(!c_mid && !oe_end && req_cnt == n0, "R9 above window", c_mid, 0);
  endtask

  task automatic t_inverted;
    int n0;
    cfg_wr(1, 0, 8'h60); cfg_wr(1, 1, 8'h50); cfg_wr(1, 4, 8'h80);
    n0 = req_cnt;
    bus(16'h5500, 1'b1, 8'h00);
    chk(!c_mid && req_cnt == n0, "R2 inverted range never matches", c_mid, 0);
  endtask

  task automatic t_priority;
    cfg_wr(2, 0, 8'h48); cfg_wr(2, 1, 8'h60); cfg_wr(2, 2, 8'h00);
    cfg_wr(2, 3, 8'h01); cfg_wr(2, 4, 8'h80);
    bus(16'h4800, 1'b1, 8'h00);
    chk(last_addr == {21'h1234D, 8'h00}, "R3 lowest index wins",
        last_addr, {21'h1234D, 8'h00});
    bus(16'h5001, 1'b1, 8'h00);
    chk(last_addr == {21'h00108, 8'h01} && rd_end == mdata({21'h00108, 8'h01}),
        "R3 next window serves", last_addr, {21'h00108, 8'h01});
  endtask

  task automatic t_write;
    int n0;
    gap = 3;
    n0 = req_cnt;
    bus(16'h4A10, 1'b0, 8'h5A);
    chk(c_mid && !oe_end, "R6 write claimed, not driven", {c_mid, oe_end}, 2);
    chk(req_cnt == n0 + 1 && last_we, "R6 one write request", req_cnt - n0, 1);
    chk(last_addr == {21'h1234F, 8'h10} && last_wd == 8'h5A, "R7 stalled write payload",
        {last_addr, last_wd}, {21'h1234F, 8'h10, 8'h5A});
    gap = 0;
  endtask

  task automatic t_cfg;
    int n0;
    bus({CFG, 8'h02}, 1'b1, 8'h00);
    chk(oe_end && rd_end == 8'h45, "R8 readback offset low", rd_end, 8'h45);
    bus({CFG, 8'h04}, 1'b1, 8'h00);
    chk(rd_end == 8'h81, "R8 readback enable field", rd_end, 8'h81);
    cfg_wr(3, 0, 8'h00); cfg_wr(3, 1, 8'hFF); cfg_wr(3, 4, 8'h80);
    n0 = req_cnt;
    bus({CFG, 8'h08}, 1'b1, 8'h00);
    chk(rd_end == 8'h60 && req_cnt == n0, "R8 page never remapped", rd_end, 8'h60);
    cfg_wr(0, 4, 8'h01);
    bus(16'h4523, 1'b1, 8'h00);
    chk(last_addr == {21'h00045, 8'h23}, "R2 disabled window skipped",
        last_addr, {21'h00045, 8'h23});
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_bounds();
    t_inverted();
    t_priority();
    t_write();
    t_cfg();
    summary();
  end
endmodule